// File: doc/BRIEF.md
# Two-Stage Ring Transmit Arbiter

This block sits in front of a token-ring fabric that has a small number of data channels. It decides which client transmitters may send, and on which channel. Each client raises a request and names the receiver it wants to reach. The arbiter first gives the client sole ownership of that receiver. Only on a later cycle does it hand the client one free data channel from the shared pool. The client keeps both resources until it pulses its done input, and both are freed on that edge.

Because every sender takes the receiver before the channel, and never the other way round, no sender can sit on a channel while it waits for a receiver. A client that wants a receiver someone else already owns waits with nothing held. A client that owns a receiver but finds every channel taken keeps the receiver and waits. A per-receiver round-robin settles contention for a receiver. A separate round-robin among clients that hold a receiver settles contention for channels, so no client is locked out for good.

The default configuration has four clients, four receivers and eight channels. All three counts are parameters.

Top module: `ring_tx_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released until the first grant, rcv_grant, ch_grant, ch_index, rcv_busy and ch_busy are all zero. Reset takes effect at once, without waiting for a clock edge.
- R2: Take a client that holds nothing, raises req_valid, and names a receiver that nobody owns. The binary receiver number sits at bits [i*DW +: DW] of req_dest. If the client wins arbitration for that receiver, rcv_grant for that client is high after the next rising edge.
- R3: At most one client owns a given receiver. A client whose target receiver is already owned holds nothing while it waits: its rcv_grant and ch_grant both stay low.
- R4: A client's ch_grant rises only if that client's rcv_grant was already high in the previous cycle. At most one new channel grant is made per cycle.
- R5: A channel grant takes the lowest-numbered free channel. The client's ch_index field, at bits [i*CW +: CW], carries that binary channel number while ch_grant is high and stays constant until release. The field is zero whenever ch_grant is low.
- R6: At most one client owns a given channel. When no channel is free, a client that holds a receiver keeps it and waits. It gets the first channel that is freed.
- R7: Each receiver has its own rotating priority. After client k is granted that receiver, the next search for it starts at client k+1.
- R8: Channels are handed out with a rotating priority among clients that hold a receiver. After client k gets a channel, the next search starts at client k+1.
- R9: A client that pulses req_done while it holds a receiver loses its receiver, and its channel if it has one, at that edge. Both can be granted to another client on the next edge. req_done from a client that holds nothing has no effect. req_valid from a client that already holds a receiver has no effect.
- R10: rcv_busy bit r is high exactly while receiver r is owned. ch_busy bit c is high exactly while channel c is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_REQ | Per-client request to transmit |
| req_dest | input | N_REQ*DW | Per-client target receiver number |
| req_done | input | N_REQ | Per-client end-of-packet pulse, releases held resources |
| rcv_grant | output | N_REQ | Client owns its target receiver |
| ch_grant | output | N_REQ | Client owns a data channel and may transmit |
| ch_index | output | N_REQ*CW | Per-client number of the owned channel |
| rcv_busy | output | N_RCV | Receiver ownership map |
| ch_busy | output | N_CH | Channel ownership map |

## Verification
The bench targets several corner cases.

- **Two clients contend for one receiver.** A design with a shared or wrongly cleared receiver lock would show two owners, or would let the waiting client take a channel early.
- **The channel pool is exhausted.** A design that dropped the receiver lock, or granted a channel twice, would fail the ownership maps.
- **Done arrives while a client holds only its receiver.** A design that let the channel grant win over done would leave a channel stuck.
- **The rotation order matters.** The cases are chosen so that a fixed-priority arbiter for either stage would pick a different winner than the rotating one.

// File: rtl/ring_arb_pkg.sv
`timescale 1ns/1ps
package ring_arb_pkg;

  // Per-client ownership phase
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,  // holds nothing
    PS_LOCKED = 2'd1,  // holds its receiver, waiting for a channel
    PS_XMIT   = 2'd2   // holds receiver and channel
  } port_state_e;

endpackage

// File: rtl/ring_rst_sync.sv
`timescale 1ns/1ps
module ring_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ring_rr_arb.sv
`timescale 1ns/1ps
// Rotating-priority picker: search starts at the slot after the last winner.
module ring_rr_arb #(
  parameter  int W  = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         adv,
  output logic [W-1:0] gnt
);

  logic [IW-1:0] ptr_q, ptr_d, win_idx;
  logic          any;
  logic          ptr_en;

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    gnt     = '0;
    for (int k = 0; k < W; k++) begin
      if (!any && req[(int'(ptr_q) + k) % W]) begin
        any     = 1'b1;
        win_idx = IW'((int'(ptr_q) + k) % W);
      end
    end
    if (any) gnt[win_idx] = 1'b1;
  end

  assign ptr_en = adv && any;
  assign ptr_d  = IW'((int'(win_idx) + 1) % W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/ring_free_pick.sv
`timescale 1ns/1ps
// Lowest-numbered free channel finder.
module ring_free_pick #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int c = N - 1; c >= 0; c--) begin
      if (!busy[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/ring_port_fsm.sv
`timescale 1ns/1ps
// Per-client ownership tracker: idle -> receiver held -> channel held.
module ring_port_fsm
  import ring_arb_pkg::*;
#(
  parameter int DW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          rcv_win,
  input  logic          ch_win,
  input  logic [DW-1:0] dest_in,
  input  logic [CW-1:0] ch_in,
  output port_state_e   state,
  output logic [DW-1:0] dest_q,
  output logic [CW-1:0] ch_q
);

  port_state_e state_q, state_d;
  logic        dest_en, ch_en;

  always_comb begin
    state_d = state_q;
    dest_en = 1'b0;
    ch_en   = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (rcv_win) begin
          state_d = PS_LOCKED;
          dest_en = 1'b1;
        end
      end
      PS_LOCKED: begin
        if (done) begin
          state_d = PS_IDLE;
        end else if (ch_win) begin
          state_d = PS_XMIT;
          ch_en   = 1'b1;
        end
      end
      PS_XMIT: begin
        if (done) state_d = PS_IDLE;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dest_q <= '0;
    else if (dest_en) dest_q <= dest_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ch_q <= '0;
    else if (ch_en) ch_q <= ch_in;
  end

  assign state = state_q;

endmodule

// File: rtl/ring_tx_arbiter.sv
`timescale 1ns/1ps
module ring_tx_arbiter
  import ring_arb_pkg::*;
#(
  parameter  int N_REQ = 4,
  parameter  int N_RCV = 4,
  parameter  int N_CH  = 8,
  localparam int DW    = $clog2(N_RCV),
  localparam int CW    = $clog2(N_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_REQ-1:0]    req_valid,
  input  logic [N_REQ*DW-1:0] req_dest,
  input  logic [N_REQ-1:0]    req_done,
  output logic [N_REQ-1:0]    rcv_grant,
  output logic [N_REQ-1:0]    ch_grant,
  output logic [N_REQ*CW-1:0] ch_index,
  output logic [N_RCV-1:0]    rcv_busy,
  output logic [N_CH-1:0]     ch_busy
);

  logic rst_n_int;

  port_state_e       st        [N_REQ];
  logic [DW-1:0]     hold_dest [N_REQ];
  logic [CW-1:0]     hold_ch   [N_REQ];

  logic [N_REQ-1:0]  rcv_cand  [N_RCV];
  logic [N_REQ-1:0]  rcv_gnt   [N_RCV];
  logic [N_REQ-1:0]  rcv_win;

  logic [N_REQ-1:0]  ch_cand, ch_gnt_raw, ch_win;
  logic              ch_free;
  logic [CW-1:0]     ch_pick;

  ring_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Ownership maps from the per-client held state
  always_comb begin
    rcv_busy = '0;
    ch_busy  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      for (int r = 0; r < N_RCV; r++) begin
        if (st[i] != PS_IDLE && hold_dest[i] == DW'(r)) rcv_busy[r] = 1'b1;
      end
      for (int c = 0; c < N_CH; c++) begin
        if (st[i] == PS_XMIT && hold_ch[i] == CW'(c)) ch_busy[c] = 1'b1;
      end
    end
  end

  // Stage one: receiver lock, one rotating arbiter per receiver
  always_comb begin
    for (int r = 0; r < N_RCV; r++) begin
      for (int i = 0; i < N_REQ; i++) begin
        rcv_cand[r][i] = req_valid[i] && (st[i] == PS_IDLE) &&
                         (req_dest[i*DW +: DW] == DW'(r)) && !rcv_busy[r];
      end
    end
  end

  for (genvar r = 0; r < N_RCV; r++) begin : g_rcv_arb
    ring_rr_arb #(.W(N_REQ)) u_rcv_arb (
      .clk   (clk),
      .rst_n (rst_n_int),
      .req   (rcv_cand[r]),
      .adv   (1'b1),
      .gnt   (rcv_gnt[r])
    );
  end

  always_comb begin
    rcv_win = '0;
    for (int r = 0; r < N_RCV; r++) rcv_win = rcv_win | rcv_gnt[r];
  end

  // Stage two: one channel per cycle to a client already holding its receiver
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      ch_cand[i] = (st[i] == PS_LOCKED) && !req_done[i];
    end
  end

  ring_free_pick #(.N(N_CH)) u_free_pick (
    .busy  (ch_busy),
    .found (ch_free),
    .idx   (ch_pick)
  );

  ring_rr_arb #(.W(N_REQ)) u_ch_arb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .req   (ch_cand),
    .adv   (ch_free),
    .gnt   (ch_gnt_raw)
  );

  assign ch_win = ch_free ? ch_gnt_raw : '0;

  // Per-client trackers and outputs
  for (genvar i = 0; i < N_REQ; i++) begin : g_port
    ring_port_fsm #(.DW(DW), .CW(CW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .done    (req_done[i]),
      .rcv_win (rcv_win[i]),
      .ch_win  (ch_win[i]),
      .dest_in (req_dest[i*DW +: DW]),
      .ch_in   (ch_pick),
      .state   (st[i]),
      .dest_q  (hold_dest[i]),
      .ch_q    (hold_ch[i])
    );

    assign rcv_grant[i]         = (st[i] != PS_IDLE);
    assign ch_grant[i]          = (st[i] == PS_XMIT);
    assign ch_index[i*CW +: CW] = (st[i] == PS_XMIT) ? hold_ch[i] : '0;
  end

endmodule

// File: rtl/ring_tx_arbiter_chk.sv
`timescale 1ns/1ps
module ring_tx_arbiter_chk #(
  parameter  int N_REQ = 4,
  parameter  int N_RCV = 4,
  parameter  int N_CH  = 8,
  localparam int CW    = $clog2(N_CH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_REQ-1:0]    req_done,
  input logic [N_REQ-1:0]    rcv_grant,
  input logic [N_REQ-1:0]    ch_grant,
  input logic [N_REQ*CW-1:0] ch_index,
  input logic [N_RCV-1:0]    rcv_busy,
  input logic [N_CH-1:0]     ch_busy
);

  // R3
  rcv_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rcv_grant) == $countones(rcv_busy));

  // R6
  ch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_grant) == $countones(ch_busy));

  // R4
  one_new_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_grant & ~$past(ch_grant)) <= 1);

  for (genvar i = 0; i < N_REQ; i++) begin : g_port_chk
    // R4
    rcv_before_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_grant[i]) |-> $past(rcv_grant[i]));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_done[i] && rcv_grant[i] |=> !rcv_grant[i] && !ch_grant[i]);

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_grant[i] && !req_done[i] |=> ch_grant[i] && $stable(ch_index[i*CW +: CW]));
  end

endmodule

bind ring_tx_arbiter ring_tx_arbiter_chk #(
  .N_REQ (N_REQ),
  .N_RCV (N_RCV),
  .N_CH  (N_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_done  (req_done),
  .rcv_grant (rcv_grant),
  .ch_grant  (ch_grant),
  .ch_index  (ch_index),
  .rcv_busy  (rcv_busy),
  .ch_busy   (ch_busy)
);

// File: tb/ring_tx_arbiter_bench.sv
`timescale 1ns/1ps
module ring_tx_arbiter_bench;

  localparam int NR = 4;
  localparam int NV = 4;
  localparam int NC = 2;
  localparam int DW = 2;
  localparam int CW = 1;
  localparam int ROWS = 27;

  // {req[4], dest[8], done[4], | rcv_grant[4], ch_grant[4], ch_index[4], rcv_busy[4], ch_busy[2]}
  localparam logic [33:0] VEC [ROWS] = '{
    {4'b0000, 8'hE5, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0001, 8'hE5, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0010, 2'b00},
    {4'b0001, 8'hE5, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0010, 2'b01},
    {4'b0011, 8'hE5, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0010, 2'b01},
    {4'b0010, 8'hE5, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0010, 8'hE5, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 2'b00},
    {4'b0010, 8'hE5, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0010, 2'b01},
    {4'b1110, 8'hE5, 4'b0000, 4'b1110, 4'b0010, 4'b0000, 4'b1110, 2'b01},
    {4'b1110, 8'hE5, 4'b0000, 4'b1110, 4'b0110, 4'b0100, 4'b1110, 2'b11},
    {4'b1110, 8'hE5, 4'b0000, 4'b1110, 4'b0110, 4'b0100, 4'b1110, 2'b11},
    {4'b1100, 8'hE5, 4'b0010, 4'b1100, 4'b0100, 4'b0100, 4'b1100, 2'b10},
    {4'b1100, 8'hE5, 4'b0000, 4'b1100, 4'b1100, 4'b0100, 4'b1100, 2'b11},
    {4'b0000, 8'hE5, 4'b1100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0111, 8'h00, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0001, 2'b00},
    {4'b0111, 8'h00, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0001, 2'b01},
    {4'b0111, 8'h00, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0111, 8'h00, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0001, 2'b00},
    {4'b0111, 8'h00, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0001, 2'b01},
    {4'b0101, 8'h00, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0101, 8'h00, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0001, 2'b00},
    {4'b0001, 8'h00, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b0001, 8'h00, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0001, 2'b00},
    {4'b0000, 8'h00, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00},
    {4'b1001, 8'hC0, 4'b0000, 4'b1001, 4'b0000, 4'b0000, 4'b1001, 2'b00},
    {4'b1001, 8'hC0, 4'b0000, 4'b1001, 4'b1000, 4'b0000, 4'b1001, 2'b01},
    {4'b1001, 8'hC0, 4'b0000, 4'b1001, 4'b1001, 4'b0001, 4'b1001, 2'b11},
    {4'b0000, 8'h00, 4'b1001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'b00}
  };

  logic                clk;
  logic                rst_n;
  logic [NR-1:0]       req_valid;
  logic [NR*DW-1:0]    req_dest;
  logic [NR-1:0]       req_done;
  logic [NR-1:0]       rcv_grant;
  logic [NR-1:0]       ch_grant;
  logic [NR*CW-1:0]    ch_index;
  logic [NV-1:0]       rcv_busy;
  logic [NC-1:0]       ch_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ring_tx_arbiter #(.N_REQ(NR), .N_RCV(NV), .N_CH(NC)) u_ring_tx_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_done  (req_done),
    .rcv_grant (rcv_grant),
    .ch_grant  (ch_grant),
    .ch_index  (ch_index),
    .rcv_busy  (rcv_busy),
    .ch_busy   (ch_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [17:0] obs();
    return {rcv_grant, ch_grant, ch_index, rcv_busy, ch_busy};
  endfunction

  function automatic string row_tag(input int r);
    if (r == 0)                 return "R1";
    else if (r <= 2)            return "R2";
    else if (r <= 4)            return "R3";
    else if (r <= 6)            return "R5";
    else if (r <= 11)           return "R6";
    else if (r == 12 || r == 22) return "R9";
    else if (r <= 21)           return "R7";
    else                        return "R8";
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = '0;
    req_dest  = '0;
    req_done  = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 during reset", obs(), 18'd0);
    do_reset();
    #1;
    check("R1 after release", obs(), 18'd0);

    // Table walk
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      req_valid = VEC[r][33:30];
      req_dest  = VEC[r][29:22];
      req_done  = VEC[r][21:18];
      @(posedge clk);
      #1;
      check($sformatf("%s row %0d", row_tag(r), r), obs(), VEC[r][17:0]);
    end

    // R9: done from idle clients has no effect
    @(negedge clk);
    req_valid = '0;
    req_done  = 4'b1111;
    @(posedge clk);
    #1;
    check("R9 done while idle", obs(), 18'd0);

    // R4 / R10: client 0 to receiver 2; lock first, channel a cycle later
    @(negedge clk);
    req_done  = '0;
    req_valid = 4'b0001;
    req_dest  = 8'h02;
    @(posedge clk);
    #1;
    check("R4 lock before channel", obs(),
          {4'b0001, 4'b0000, 4'b0000, 4'b0100, 2'b00});
    @(posedge clk);
    #1;
    check("R10 busy maps with channel", obs(),
          {4'b0001, 4'b0001, 4'b0000, 4'b0100, 2'b01});

    // R1: asynchronous reset in the middle of a transfer
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", obs(), 18'd0);
    req_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 idle after reset", obs(), 18'd0);

    finish_run();
  end

endmodule